// File: doc/BRIEF.md
# Phase-Offset PWM Generator

This block produces one pulse-width modulated output whose timing is set by three programmable values. These are the period, the active length (duty) and a phase offset. All three are counted in prescaled ticks, and a new tick arrives once every `TICK_DIV` clocks. Within each period a counter runs from zero up to one less than the period. The output is active for `duty` counts, starting at the offset count. When offset plus duty runs past the end of the period, the active window wraps around into the start of the period.

Software writes the timing values through a small register write port and can read them back combinationally. Writes land in shadow copies. The running waveform picks them up only when the next period begins, so a change never cuts a period short. A two-bit enable field must hold both bits set for the channel to run. A polarity bit inverts the output. Clearing an enable bit stops the channel at once, and the output holds whatever level it had at that moment. A one-clock pulse marks the first clock of every period.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset, `pwm_out` and `period_start` are 0, and reads of all four register addresses return 0.
- R2: Address 0 holds the period, address 1 the duty and address 2 the offset. Address 3 is control: bits 1:0 are the enable field and bit 2 is polarity. A read returns the last written value. Control bits 7:3 are discarded and read as 0.
- R3: While running, the count advances once every `TICK_DIV` clocks from 0 to period−1 and then wraps. `period_start` is high for exactly the first clock of count 0 in every period, including the first period after a start.
- R4: With 0 < duty < period, the level is active when (count − offset) mod period < duty, so a window that runs past period−1 continues at count 0. An offset equal to or above the period is treated as 0.
- R5: Duty 0 gives a constant inactive level. Duty equal to or above the period gives a constant active level.
- R6: `pwm_out` shows the window result for the count of the previous clock, one clock of latency.
- R7: Period, duty and offset writes made while running take effect at the next period start and not earlier.
- R8: The channel starts only when the enable field is 2'b11 and the shadow period is nonzero. The first period begins two clocks after the control write. Enable values 01, 10 and 00 leave it stopped.
- R9: Once an enable bit is cleared, the channel stops. The output holds the level it had in the clock after the control write, and `period_start` stays low.
- R10: If the shadow period is 0 when a period ends, the channel stops at that boundary with no `period_start` pulse, and the output holds its last level.
- R11: Enabling a stopped channel restarts the count at 0 with the latest shadow values. The output keeps its held level during the first clock of that period.
- R12: Polarity bit 1 inverts the output level. A change made while running shows on `pwm_out` two clocks after the control write.
- R13: Writing control with enable 2'b11 while the channel runs does not restart it: no extra `period_start` and no break in the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Read data of the addressed register (combinational) |
| pwm_out | output | 1 | Modulated output |
| period_start | output | 1 | One-clock pulse in the first clock of each period |

## Verification
The assertions assume the write port never changes the enable field while the reset is high. They also assume that software only ever places a nonzero period into the running configuration through the start or boundary load. Both hold because the bench drives every input from the falling clock edge and keeps the write strobe low while reset is held. The bench changes the configuration only through complete register writes. It sweeps every period from 1 to 6, every duty and offset from 0 to 7, and both polarities. Offsets above the period and duties at or above it are therefore reached as ordinary register values, not as out-of-range stimulus.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PWM_W = 8;

    typedef logic [PWM_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t period;
        cnt_t duty;
        cnt_t offset;
    } wave_cfg_t;

    typedef struct packed {
        logic       invert;
        logic [1:0] en;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_PERIOD = 2'd0,
        REG_DUTY   = 2'd1,
        REG_OFFSET = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    localparam logic [1:0] EN_RUN = 2'b11;

    // Window test: active when the distance from the start count, taken
    // around the period, is below the duty. Offset >= period starts at 0.
    function automatic logic in_window(cnt_t cnt, wave_cfg_t cfg);
        cnt_t         start;
        logic [PWM_W:0] rel;
        logic         hit;
        start = (cfg.offset >= cfg.period) ? '0 : cfg.offset;
        if (cnt >= start)
            rel = {1'b0, cnt} - {1'b0, start};
        else
            rel = {1'b0, cnt} + {1'b0, cfg.period} - {1'b0, start};
        if (cfg.duty == '0)
            hit = 1'b0;
        else if (cfg.duty >= cfg.period)
            hit = 1'b1;
        else
            hit = (rel < {1'b0, cfg.duty});
        return hit;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [PWM_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [PWM_W-1:0] rd_data,
    output wave_cfg_t        shadow,
    output ctrl_t            ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            ctrl   <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_PERIOD: shadow.period <= wr_data;
                REG_DUTY:   shadow.duty   <= wr_data;
                REG_OFFSET: shadow.offset <= wr_data;
                default:    ctrl          <= ctrl_t'(wr_data[2:0]);
            endcase
        end
    end

    always_comb begin
        case (reg_sel_e'(rd_addr))
            REG_PERIOD: rd_data = shadow.period;
            REG_DUTY:   rd_data = shadow.duty;
            REG_OFFSET: rd_data = shadow.offset;
            default:    rd_data = {{(PWM_W-3){1'b0}}, ctrl};
        endcase
    end

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam logic [PW-1:0] LAST = (PW)'(DIV - 1);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst || !run)
                    pre_q <= '0;
                else if (pre_q == LAST)
                    pre_q <= '0;
                else
                    pre_q <= pre_q + (PW)'(1);
            end
            assign tick = run && (pre_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  wave_cfg_t shadow,
    input  ctrl_t     ctrl,
    output logic      run,
    output logic      level,
    output logic      period_start
);

    localparam cnt_t ONE = cnt_t'(1);

    logic      run_q, lvl_q, pstart_q;
    cnt_t      cnt_q;
    wave_cfg_t act_q;
    logic      want;

    assign want = (ctrl.en == EN_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            lvl_q    <= 1'b0;
            pstart_q <= 1'b0;
            cnt_q    <= '0;
            act_q    <= '0;
        end else begin
            pstart_q <= 1'b0;
            if (!run_q) begin
                if (want && shadow.period != '0) begin
                    run_q    <= 1'b1;
                    act_q    <= shadow;
                    cnt_q    <= '0;
                    pstart_q <= 1'b1;
                end
            end else if (!want) begin
                run_q <= 1'b0;
            end else begin
                lvl_q <= ctrl.invert ^ in_window(cnt_q, act_q);
                if (tick) begin
                    if (cnt_q == act_q.period - ONE) begin
                        cnt_q <= '0;
                        if (shadow.period == '0) begin
                            run_q <= 1'b0;
                        end else begin
                            act_q    <= shadow;
                            pstart_q <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
            end
        end
    end

    assign run          = run_q;
    assign level        = lvl_q;
    assign period_start = pstart_q;

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> $stable(lvl_q)); // R9
    AST_START_BOTH_BITS: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> $past(ctrl.en) == EN_RUN); // R8
    AST_START_NONZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> act_q.period != '0); // R8
    AST_PSTART_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        pstart_q |-> cnt_q == '0); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_q |-> cnt_q < act_q.period); // R3
    AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !pstart_q |-> $stable(act_q)); // R7

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
    import pwm_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [PWM_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [PWM_W-1:0] rd_data,
    output logic             pwm_out,
    output logic             period_start
);

    wave_cfg_t shadow;
    ctrl_t     ctrl;
    logic      run, tick;

    pwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .shadow  (shadow),
        .ctrl    (ctrl)
    );

    pwm_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    pwm_engine u_engine (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .shadow       (shadow),
        .ctrl         (ctrl),
        .run          (run),
        .level        (pwm_out),
        .period_start (period_start)
    );

    AST_PSTART_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        period_start && TICK_DIV > 1 |=> !period_start); // R3

endmodule

// File: tb/test_pwm_phase_gen.sv
module test_pwm_phase_gen;

    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pwm_out, period_start;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_phase_gen #(.TICK_DIV(TDIV)) i_pwm_phase_gen (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int expw(int c, int p, int d, int o, int pol);
        int s;
        int a;
        s = (o >= p) ? 0 : o;
        if (d == 0) a = 0;
        else if (d >= p) a = 1;
        else a = (((c - s + p) % p) < d) ? 1 : 0;
        return a ^ pol;
    endfunction

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Ends in cycle 0 of the first period (R8 latency).
    task automatic configure(input int p, input int d, input int o, input int pol);
        wr(3, 0); wr(0, p); wr(1, d); wr(2, o);
        wr(3, (pol << 2) | 3);
        @(negedge clk);
    endtask

    task automatic check_run(input int p, input int d, input int o, input int pol,
                             input int n, input string tag);
        for (int j = 0; j <= n; j++) begin
            if (j > 0) chk(tag, pwm_out, expw(((j-1)/TDIV) % p, p, d, o, pol));
            chk("R3", period_start, (j % (p*TDIV)) == 0 ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic freeze_at(input int jw, input int held);
        for (int j = 0; j <= jw; j++) begin
            if (j > 0) chk("R9", pwm_out, expw(((j-1)/TDIV) % 8, 8, 4, 0, 0));
            if (j == jw) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00; end
            @(negedge clk);
        end
        wr_en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            chk("R9", pwm_out, held);
            chk("R9", period_start, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog timeout actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", pwm_out, 0);
        chk("R1", period_start, 0);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            chk("R1", rd_data, 0);
        end

        // R2 readback
        wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'h81); wr(3, 8'hF8);
        rd_addr = 2'd0; #1; chk("R2", rd_data, 8'hA5);
        rd_addr = 2'd1; #1; chk("R2", rd_data, 8'h3C);
        rd_addr = 2'd2; #1; chk("R2", rd_data, 8'h81);
        rd_addr = 2'd3; #1; chk("R2", rd_data, 0);
        wr(3, 8'h06);
        rd_addr = 2'd3; #1; chk("R2", rd_data, 8'h06);
        wr(3, 0);

        // R4 R6 wrapped window example
        configure(10, 6, 6, 0);
        check_run(10, 6, 6, 0, 2*10*TDIV, "R4 R6");

        // Sweep: R3, R4, R5
        for (int p = 1; p <= 6; p++)
            for (int d = 0; d <= 7; d++)
                for (int o = 0; o <= 7; o++)
                    for (int pol = 0; pol <= 1; pol++) begin
                        configure(p, d, o, pol);
                        check_run(p, d, o, pol, 2*p*TDIV,
                                  (d == 0 || d >= p) ? "R5" : "R4");
                    end

        // R7 shadow update at boundary, R13 control rewrite while running
        configure(8, 2, 0, 0);
        for (int j = 0; j <= 48; j++) begin
            if (j > 0) chk("R7", pwm_out,
                           expw(((j-1)/TDIV) % 8, 8, (((j-1)/16) == 0) ? 2 : 5, 0, 0));
            chk("R13", period_start, (j % 16) == 0 ? 1 : 0);
            if (j == 3) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd5; end
            else if (j == 6) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h03; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R12 polarity change while running
        configure(4, 2, 0, 0);
        for (int j = 0; j <= 16; j++) begin
            if (j > 0) chk("R12", pwm_out, expw(((j-1)/TDIV) % 4, 4, 2, 0, (j >= 4) ? 1 : 0));
            if (j == 2) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h07; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R9 freeze low, then freeze high
        configure(8, 4, 0, 0);
        freeze_at(9, 0);
        configure(8, 4, 0, 0);
        freeze_at(3, 1);

        // R11 restart with latest shadow values
        wr(1, 2); wr(2, 5); wr(3, 3);
        @(negedge clk);
        chk("R11", pwm_out, 1);
        check_run(8, 2, 5, 0, 16, "R11");

        // R8 partial enables and zero period
        wr(3, 0);
        @(negedge clk);
        held = pwm_out;
        wr(3, 1);
        for (int k = 0; k < 8; k++) begin
            chk("R8", pwm_out, held); chk("R8", period_start, 0); @(negedge clk);
        end
        wr(3, 2);
        for (int k = 0; k < 8; k++) begin
            chk("R8", pwm_out, held); chk("R8", period_start, 0); @(negedge clk);
        end
        wr(3, 0); wr(0, 0); wr(3, 3);
        for (int k = 0; k < 8; k++) begin
            chk("R8", pwm_out, held); chk("R8", period_start, 0); @(negedge clk);
        end

        // R10 zero period loaded at boundary stops the channel
        configure(4, 1, 3, 0);
        for (int j = 0; j <= 20; j++) begin
            if (j < 8) begin
                if (j > 0) chk("R10", pwm_out, expw(((j-1)/TDIV) % 4, 4, 1, 3, 0));
                chk("R10", period_start, (j % 8) == 0 ? 1 : 0);
            end else begin
                chk("R10", pwm_out, 1);
                chk("R10", period_start, 0);
            end
            if (j == 2) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd0; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule